// File: doc/BRIEF.md
# Gated 22 kHz Tone Controller

This block divides the system clock down to a 22 kHz square wave and gates it for signalling to a satellite outdoor unit. The tone can run under register control as a steady carrier. It can also be keyed by an asynchronous TTL data input. Keying has a fixed turn-on delay of about 25 µs and an equal turn-off delay. The tone is allowed only while the supply regulator is enabled and the tone-transmit enable is high.

A second output, `tone_act_o`, is high while the internal generator is emitting. It is meant to drive an optional active pull-down on the output rail. All control pins are plain levels. There is no data stream and no handshake.

The half-period is `HALF = round(CLK_HZ / (2*TONE_HZ))` clock cycles. The keying delay is `DLY = floor(CLK_HZ * DELAY_US / 1e6)` clock cycles.

Top module: `tone_gate_ctrl`

## Requirements
- R1: While running, the tone is a square wave whose high and low phases each last exactly HALF clock cycles.
- R2: Whenever the generator starts, its first phase is a full high phase of HALF cycles, so no runt pulse appears.
- R3: On the first clock edge at which `tx_en_i` is sampled low, the generator stops: `tone_o` and `tone_act_o` both read 0 after that edge.
- R4: On the first clock edge at which `supply_en_i` is sampled low, the generator likewise stops, whatever `tx_en_i` and `steady_i` are.
- R5: With `supply_en_i`, `tx_en_i` and `steady_i` all high, the tone runs continuously, whatever `key_i` is.
- R6: After `key_i` rises and stays high, `tone_act_o` rises on the (DLY+3)th rising clock edge: two synchroniser stages plus DLY delay cycles plus the generator register.
- R7: After `key_i` falls and stays low, `tone_act_o` falls on the (DLY+3)th rising clock edge.
- R8: A level on `key_i` held for fewer than DLY clock edges has no effect on the outputs. A level held for exactly DLY edges does pass.
- R9: While `tx_en_i` or `supply_en_i` is low, the keying delay is cleared. If `key_i` is high when the gate re-opens, the tone restarts on the (DLY+1)th edge after re-opening.
- R10: `tone_act_o` is high exactly while the generator runs, and `tone_o` is never high while `tone_act_o` is low.
- R11: While `rst_ni` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock of CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_en_i | input | 1 | Regulator enable; low forces the tone off |
| tx_en_i | input | 1 | Tone-transmit enable; low forces the tone off |
| steady_i | input | 1 | Request for a continuous tone |
| key_i | input | 1 | Asynchronous keying input, high requests tone |
| tone_o | output | 1 | 22 kHz square-wave output |
| tone_act_o | output | 1 | High while the internal tone is emitted |

## Verification
The assertions assume that `supply_en_i`, `tx_en_i` and `steady_i` are synchronous to `clk_i` and held for whole cycles. Only `key_i` may change at any time. The stimulus respects this by changing every input at the falling edge.

The stimulus keeps the key level steady for at least DLY cycles, except in the pulse-width cases that target R8. It samples outputs at the falling edge, half a cycle after the register that drives them.

// File: rtl/tone_pkg.sv
`timescale 1ns/1ps
package tone_pkg;
  // Half-period in clock cycles, rounded to the nearest whole count.
  function automatic int half_cycles(input int clk_hz, input int tone_hz);
    return (clk_hz + tone_hz) / (2 * tone_hz);
  endfunction

  // Keying delay in clock cycles, rounded down.
  function automatic int delay_cycles(input int clk_hz, input int delay_us);
    return ((clk_hz / 1000) * delay_us) / 1000;
  endfunction

  // Counter width able to hold values 0..n-1, at least one bit.
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tone_key_sync.sv
`timescale 1ns/1ps
module tone_key_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tone_key_delay.sv
`timescale 1ns/1ps
module tone_key_delay #(
  parameter int DLY = 3125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic lvl_i,
  output logic keyed_o
);
  localparam int DW = tone_pkg::cnt_width(DLY);
  localparam logic [DW-1:0] LAST = DW'(DLY - 1);

  logic [DW-1:0] cnt_q;
  logic          keyed_q;

  // The output follows the input only after the input has differed from it
  // for DLY consecutive cycles; shorter excursions restart the count.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      keyed_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      keyed_q <= 1'b0;
    end else if (lvl_i == keyed_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      keyed_q <= lvl_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign keyed_o = keyed_q;
endmodule

// File: rtl/tone_divider.sv
`timescale 1ns/1ps
module tone_divider #(
  parameter int HALF = 2841
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tone_o,
  output logic active_o
);
  localparam int CW = tone_pkg::cnt_width(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      phase_q <= 1'b1;
      cnt_q   <= '0;
    end else if (!run_i) begin
      act_q   <= 1'b0;
      phase_q <= 1'b1;
      cnt_q   <= '0;
    end else if (!act_q) begin
      // first running cycle: open a fresh high phase
      act_q   <= 1'b1;
      phase_q <= 1'b1;
      cnt_q   <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tone_o   = act_q & phase_q;
  assign active_o = act_q;
endmodule

// File: rtl/tone_gate_ctrl.sv
`timescale 1ns/1ps
module tone_gate_ctrl #(
  parameter int CLK_HZ   = 125_000_000,
  parameter int TONE_HZ  = 22_000,
  parameter int DELAY_US = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_en_i,
  input  logic tx_en_i,
  input  logic steady_i,
  input  logic key_i,
  output logic tone_o,
  output logic tone_act_o
);
  localparam int HALF = tone_pkg::half_cycles(CLK_HZ, TONE_HZ);
  localparam int DLY  = tone_pkg::delay_cycles(CLK_HZ, DELAY_US);

  logic key_sync;
  logic key_dly;
  logic gate_open;
  logic run;

  assign gate_open = supply_en_i & tx_en_i;

  tone_key_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (key_i),
    .sync_o  (key_sync)
  );

  tone_key_delay #(.DLY(DLY)) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (~gate_open),
    .lvl_i   (key_sync),
    .keyed_o (key_dly)
  );

  assign run = gate_open & (steady_i | key_dly);

  tone_divider #(.HALF(HALF)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .tone_o   (tone_o),
    .active_o (tone_act_o)
  );
endmodule

// File: rtl/tone_gate_chk.sv
`timescale 1ns/1ps
module tone_gate_chk #(
  parameter int CLK_HZ  = 125_000_000,
  parameter int TONE_HZ = 22_000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_en_i,
  input logic tx_en_i,
  input logic steady_i,
  input logic tone_o,
  input logic tone_act_o
);
  localparam int HALF = tone_pkg::half_cycles(CLK_HZ, TONE_HZ);

  int   run_len_q;
  logic tone_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len_q <= 0;
      tone_q    <= 1'b0;
    end else begin
      tone_q <= tone_o;
      if (!tone_act_o)          run_len_q <= 0;
      else if (tone_o != tone_q) run_len_q <= 1;
      else                      run_len_q <= run_len_q + 1;
    end
  end

  // R1
  phase_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tone_act_o && $past(tone_act_o) && (tone_o != $past(tone_o))) |-> (run_len_q == HALF));

  // R2
  start_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tone_act_o) |-> tone_o);

  // R3
  tx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !tone_act_o);

  // R4
  supply_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_en_i |=> !tone_act_o);

  // R5
  steady_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_en_i && tx_en_i && steady_i) |=> tone_act_o);

  // R10
  tone_needs_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_o |-> tone_act_o);
endmodule

bind tone_gate_ctrl tone_gate_chk #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .supply_en_i (supply_en_i),
  .tx_en_i     (tx_en_i),
  .steady_i    (steady_i),
  .tone_o      (tone_o),
  .tone_act_o  (tone_act_o)
);

// File: tb/sim_tone_gate_ctrl.sv
`timescale 1ns/1ps
module sim_tone_gate_ctrl;
  localparam int CLK_HZ   = 2_310_000;
  localparam int TONE_HZ  = 22_000;
  localparam int DELAY_US = 25;
  // 2.31 MHz / 44 kHz = 52.5 -> rounds to 53 ; 57.75 cycles -> 57
  localparam int EXP_HALF = $rtoi(real'(CLK_HZ) / (2.0 * real'(TONE_HZ)) + 0.5);
  localparam int EXP_DLY  = (CLK_HZ * DELAY_US) / 1_000_000;

  logic clk = 1'b0;
  logic rst_n, supply_en, tx_en, steady, key;
  logic tone, tone_act;
  int   checks = 0;
  int   fails  = 0;

  always #4 clk = ~clk;

  tone_gate_ctrl #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .DELAY_US(DELAY_US)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .supply_en_i(supply_en), .tx_en_i(tx_en),
    .steady_i(steady), .key_i(key), .tone_o(tone), .tone_act_o(tone_act)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // count negedge samples over n cycles in which tone_act is high
  task automatic count_active(input int n, output int highs, output int bad);
    highs = 0;
    bad   = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tone_act) highs++;
      if (tone && !tone_act) bad++;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200_000 * 8);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int highs, bad, seg, run_len;
    logic prev;
    rst_n = 1'b0; supply_en = 1'b0; tx_en = 1'b0; steady = 1'b0; key = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 tone in reset", int'(tone), 0);
    chk("R11 act in reset", int'(tone_act), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 / R1 / R2: steady carrier, key held low
    supply_en = 1'b1; tx_en = 1'b1; steady = 1'b1;
    @(negedge clk);
    chk("R2 first phase high", int'(tone), 1);
    chk("R5 steady active", int'(tone_act), 1);
    prev = tone; run_len = 1; seg = 0;
    while (seg < 10) begin
      @(negedge clk);
      if (!tone_act) begin
        chk("R5 steady dropped", 0, 1);
        seg = 10;
      end else if (tone == prev) run_len++;
      else begin
        chk("R1 phase length", run_len, EXP_HALF);
        seg++; run_len = 1; prev = tone;
      end
    end

    // R3: transmit enable low
    tx_en = 1'b0;
    @(negedge clk);
    chk("R3 act after tx off", int'(tone_act), 0);
    chk("R3 tone after tx off", int'(tone), 0);
    count_active(200, highs, bad);
    chk("R3 stays off", highs, 0);

    // R4: supply low with the others high
    tx_en = 1'b1; supply_en = 1'b0;
    @(negedge clk);
    chk("R4 act with supply off", int'(tone_act), 0);
    key = 1'b1;
    count_active(200, highs, bad);
    chk("R4 stays off", highs, 0);
    key = 1'b0;
    supply_en = 1'b1; steady = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5 off without steady or key", int'(tone_act), 0);

    // R6 / R7: keyed timing
    key = 1'b1;
    repeat (EXP_DLY + 2) @(posedge clk);
    @(negedge clk);
    chk("R6 before start edge", int'(tone_act), 0);
    @(posedge clk); @(negedge clk);
    chk("R6 at start edge", int'(tone_act), 1);
    chk("R2 keyed start high", int'(tone), 1);
    count_active(300, highs, bad);
    chk("R6 keyed tone sustained", highs, 300);
    chk("R10 tone only with act", bad, 0);
    key = 1'b0;
    repeat (EXP_DLY + 2) @(posedge clk);
    @(negedge clk);
    chk("R7 before stop edge", int'(tone_act), 1);
    @(posedge clk); @(negedge clk);
    chk("R7 at stop edge", int'(tone_act), 0);
    chk("R7 tone low", int'(tone), 0);

    // R8: pulse width boundary
    repeat (10) @(negedge clk);
    key = 1'b1;
    repeat (EXP_DLY - 1) @(posedge clk);
    @(negedge clk);
    key = 1'b0;
    count_active(3 * EXP_DLY, highs, bad);
    chk("R8 short pulse ignored", highs, 0);
    key = 1'b1;
    repeat (EXP_DLY) @(posedge clk);
    @(negedge clk);
    key = 1'b0;
    count_active(3 * EXP_DLY, highs, bad);
    chk("R8 pulse of DLY passes", int'(highs > 0), 1);
    repeat (10) @(negedge clk);

    // R9: gate closes and reopens with key still high
    key = 1'b1;
    repeat (EXP_DLY + 10) @(negedge clk);
    chk("R9 keyed tone running", int'(tone_act), 1);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R3 keyed tone cut", int'(tone_act), 0);
    tx_en = 1'b1;
    repeat (EXP_DLY) @(posedge clk);
    @(negedge clk);
    chk("R9 before restart edge", int'(tone_act), 0);
    @(posedge clk); @(negedge clk);
    chk("R9 at restart edge", int'(tone_act), 1);
    key = 1'b0;
    count_active(3 * EXP_DLY, highs, bad);
    chk("R10 no tone without act", bad, 0);

    summary();
    $finish;
  end
endmodule